// File: doc/BRIEF.md
# PWM Timer-Counter Channel

This block is one channel of a pulse-width modulator that doubles as a general timer. A counter advances once per count tick. The tick is either every clock or a chosen edge of an external tick input. The counter is compared with two reference registers. The low reference sets the length of the period: the counter runs from zero up to one below it and then returns to zero. The high reference sets where the output turns on within that period. Software sets normal polarity by loading the high reference with period minus duty. The output is then high for the final duty ticks of every period. Loading the duty value itself gives the inverted waveform.

All four registers are reached through a simple single-cycle bus with word indices. A write takes effect at the clock edge. Read data comes back registered, one cycle later. The control word has these bits:
- run enable and output enable, which must both be set for the channel to count and drive its output;
- single-shot mode;
- a hold bit that keeps the counter at zero;
- an interrupt enable, and a pending flag that is cleared by writing 1 to it;
- external tick selection, and a falling-edge select;
- capture enable.

When capture is enabled, the selected edge on the capture input copies the counter into the high reference.

Top module: `pwmtc_chan`

## Requirements
- R1: Word index 0 is the counter, 1 the high reference, 2 the low reference and 3 the control word. Writes with `bus_wr` take effect at the clock edge. `bus_rdata` shows the register selected by `bus_addr` (its value before that edge) one cycle later. Indices 4 and above read as zero, and writes to them change nothing.
- R2: Control bit 0 is run enable, bit 1 is external tick select, bit 2 selects falling edges (rising when clear), bit 3 is output enable, bit 4 is single-shot, bit 5 is interrupt enable, bit 6 is interrupt pending, bit 7 is counter hold and bit 8 is capture enable. Bits 31..9 read as zero. Bit 2 applies to both the external tick input and the capture input.
- R3: The counter advances by one per count tick only while run enable and output enable are both 1. A count tick is every clock when bit 1 is 0. When bit 1 is 1, a count tick is each selected edge of `ext_tick_in`. An edge is a change from the input value sampled at the previous clock.
- R4: When the counter's next value would equal the low reference, the counter returns to zero instead. The counter therefore takes the values 0 to low-1, and the period is low ticks long.
- R5: `pwm_out` is registered. After each edge it is 1 exactly when the channel was active before that edge and the new counter value lies in [high, low). As a result, high = low - duty gives duty high ticks per period, equal references keep the output low, a high reference of 0 keeps it high, and an inactive channel drives 0.
- R6: In single-shot mode, the run enable bit clears itself at the low-reference wrap and counting stops. A control write in the same cycle takes priority.
- R7: Every wrap sets the pending bit. Writing 1 to bit 6 clears it, and writing 0 leaves it unchanged. A wrap in the same cycle as a clear leaves it set. `irq_out` is pending AND interrupt enable.
- R8: While the hold bit is 1, the counter is zero. This overrides counting and software writes.
- R9: A software write to the counter loads that value and takes priority over counting.
- R10: When capture is enabled, a selected edge on `cap_in` copies the counter value from before that edge into the high reference. A software write to the high reference in the same cycle takes priority.
- R11: Reset clears every register and drives `pwm_out`, `irq_out` and `bus_rdata` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | AW (4) | Register word index |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Registered read data |
| ext_tick_in | input | 1 | External count tick input, already synchronous |
| cap_in | input | 1 | Capture trigger input, already synchronous |
| pwm_out | output | 1 | PWM waveform |
| irq_out | output | 1 | Interrupt request |

## Verification
A wrong counter value reaches the ports in two ways. `pwm_out` shows it on the next clock, because the output window is evaluated on the new count. A read of index 0 shows it one cycle after the address is presented. The bench therefore compares both on every cycle against a model that steps with the same inputs. A wrongly timed or missed wrap has other visible effects. The pending bit and `irq_out` change in the cycle after the wrap, a single-shot run enable fails to clear, and the length of the high run within a period is wrong. A corrupted edge-detect state miscounts external ticks, or captures into the high reference at the wrong time. This shows on the next read of the counter or the high reference.

// File: rtl/pwmtc_pkg.sv
`timescale 1ns/1ps
package pwmtc_pkg;
  // control word bit positions (software visible)
  localparam int CB_RUN   = 0;
  localparam int CB_EXT   = 1;
  localparam int CB_FALL  = 2;
  localparam int CB_OUTEN = 3;
  localparam int CB_SHOT  = 4;
  localparam int CB_IEN   = 5;
  localparam int CB_PEND  = 6;
  localparam int CB_HOLD  = 7;
  localparam int CB_CAP   = 8;
  localparam int CTRL_W   = 9;

  typedef enum logic [1:0] {
    IX_COUNT = 2'd0,
    IX_HIGH  = 2'd1,
    IX_LOW   = 2'd2,
    IX_CTRL  = 2'd3
  } reg_ix_t;
endpackage

// File: rtl/pwmtc_edge.sv
`timescale 1ns/1ps
module pwmtc_edge (
  input  logic clk,
  input  logic rst,
  input  logic sig_i,
  input  logic fall_i,
  output logic edge_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sig_i;
  end

  assign edge_o = fall_i ? (prev_q & ~sig_i) : (~prev_q & sig_i);
endmodule

// File: rtl/pwmtc_core.sv
`timescale 1ns/1ps
module pwmtc_core #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active_i,
  input  logic          tick_i,
  input  logic          hold_i,
  input  logic          load_i,
  input  logic [DW-1:0] load_val_i,
  input  logic [DW-1:0] hi_i,
  input  logic [DW-1:0] lo_i,
  output logic [DW-1:0] cnt_o,
  output logic          pwm_o,
  output logic          wrap_o
);
  logic [DW-1:0] cnt_q, cnt_n, nxt;
  logic          adv, hit, pwm_q;

  always_comb begin
    nxt = cnt_q + 1'b1;
    adv = active_i & tick_i & ~hold_i & ~load_i;
    hit = (nxt == lo_i);
    if (hold_i)      cnt_n = '0;
    else if (load_i) cnt_n = load_val_i;
    else if (adv)    cnt_n = hit ? '0 : nxt;
    else             cnt_n = cnt_q;
  end

  assign wrap_o = adv & hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      pwm_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      pwm_q <= active_i && (cnt_n >= hi_i) && (cnt_n < lo_i);
    end
  end

  assign cnt_o = cnt_q;
  assign pwm_o = pwm_q;
endmodule

// File: rtl/pwmtc_regs.sv
`timescale 1ns/1ps
module pwmtc_regs
  import pwmtc_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] cnt_i,
  input  logic          wrap_i,
  input  logic          cap_edge_i,
  output logic [DW-1:0] hi_o,
  output logic [DW-1:0] lo_o,
  output logic          active_o,
  output logic          ext_o,
  output logic          fall_o,
  output logic          hold_o,
  output logic          irq_o,
  output logic          cnt_load_o,
  output logic [DW-1:0] rdata_o
);
  logic              mapped;
  reg_ix_t           ix;
  logic [DW-1:0]     hi_q, lo_q, rd_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              wr_hi, wr_lo, wr_ctrl;

  generate
    if (AW > 2) begin : g_dec
      assign mapped = (addr_i[AW-1:2] == '0);
    end else begin : g_full
      assign mapped = 1'b1;
    end
  endgenerate

  assign ix         = reg_ix_t'(addr_i[1:0]);
  assign cnt_load_o = wr_i & mapped & (ix == IX_COUNT);
  assign wr_hi      = wr_i & mapped & (ix == IX_HIGH);
  assign wr_lo      = wr_i & mapped & (ix == IX_LOW);
  assign wr_ctrl    = wr_i & mapped & (ix == IX_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (wr_hi)                          hi_q <= wdata_i;
      else if (ctrl_q[CB_CAP] && cap_edge_i) hi_q <= cnt_i;
      if (wr_lo) lo_q <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata_i[CTRL_W-1:0];
      else if (wrap_i && ctrl_q[CB_SHOT]) ctrl_q[CB_RUN] <= 1'b0;
      ctrl_q[CB_PEND] <= wrap_i | (ctrl_q[CB_PEND] & ~(wr_ctrl & wdata_i[CB_PEND]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !mapped) rd_q <= '0;
    else begin
      case (ix)
        IX_COUNT: rd_q <= cnt_i;
        IX_HIGH:  rd_q <= hi_q;
        IX_LOW:   rd_q <= lo_q;
        default:  rd_q <= {{(DW-CTRL_W){1'b0}}, ctrl_q};
      endcase
    end
  end

  assign hi_o     = hi_q;
  assign lo_o     = lo_q;
  assign active_o = ctrl_q[CB_RUN] & ctrl_q[CB_OUTEN];
  assign ext_o    = ctrl_q[CB_EXT];
  assign fall_o   = ctrl_q[CB_FALL];
  assign hold_o   = ctrl_q[CB_HOLD];
  assign irq_o    = ctrl_q[CB_PEND] & ctrl_q[CB_IEN];
  assign rdata_o  = rd_q;
endmodule

// File: rtl/pwmtc_chan.sv
`timescale 1ns/1ps
module pwmtc_chan #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          ext_tick_in,
  input  logic          cap_in,
  output logic          pwm_out,
  output logic          irq_out
);
  localparam int N_EDGE = 2;

  logic [DW-1:0]     cnt_w, hi_w, lo_w;
  logic              active_w, ext_w, fall_w, hold_w, load_w, wrap_w, tick_w;
  logic [N_EDGE-1:0] edge_src, edge_hit;

  assign edge_src = {cap_in, ext_tick_in};

  generate
    for (genvar g = 0; g < N_EDGE; g++) begin : g_edge
      pwmtc_edge edge_i (
        .clk    (clk),
        .rst    (rst),
        .sig_i  (edge_src[g]),
        .fall_i (fall_w),
        .edge_o (edge_hit[g])
      );
    end
  endgenerate

  assign tick_w = ext_w ? edge_hit[0] : 1'b1;

  pwmtc_regs #(.DW(DW), .AW(AW)) regs_i (
    .clk        (clk),
    .rst        (rst),
    .wr_i       (bus_wr),
    .addr_i     (bus_addr),
    .wdata_i    (bus_wdata),
    .cnt_i      (cnt_w),
    .wrap_i     (wrap_w),
    .cap_edge_i (edge_hit[1]),
    .hi_o       (hi_w),
    .lo_o       (lo_w),
    .active_o   (active_w),
    .ext_o      (ext_w),
    .fall_o     (fall_w),
    .hold_o     (hold_w),
    .irq_o      (irq_out),
    .cnt_load_o (load_w),
    .rdata_o    (bus_rdata)
  );

  pwmtc_core #(.DW(DW)) core_i (
    .clk        (clk),
    .rst        (rst),
    .active_i   (active_w),
    .tick_i     (tick_w),
    .hold_i     (hold_w),
    .load_i     (load_w),
    .load_val_i (bus_wdata),
    .hi_i       (hi_w),
    .lo_i       (lo_w),
    .cnt_o      (cnt_w),
    .pwm_o      (pwm_out),
    .wrap_o     (wrap_w)
  );
endmodule

// File: rtl/pwmtc_chk.sv
`timescale 1ns/1ps
module pwmtc_chk #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_rdata,
  input logic          pwm_out,
  input logic          irq_out,
  input logic [DW-1:0] cnt_w,
  input logic [DW-1:0] hi_w,
  input logic [DW-1:0] lo_w,
  input logic          active_w,
  input logic          ext_w,
  input logic          hold_w
);
  logic wr_cnt;
  assign wr_cnt = bus_wr && (bus_addr == '0);

  p_reset_quiet_r11: assert property (@(posedge clk)
    rst |=> (!pwm_out && !irq_out && bus_rdata == '0));

  p_inactive_low_r5: assert property (@(posedge clk) disable iff (rst)
    !active_w |=> !pwm_out);

  p_window_r5: assert property (@(posedge clk) disable iff (rst)
    (pwm_out && $stable(hi_w) && $stable(lo_w)) |-> (cnt_w >= hi_w && cnt_w < lo_w));

  p_stall_r3: assert property (@(posedge clk) disable iff (rst)
    (!active_w && !hold_w && !wr_cnt) |=> $stable(cnt_w));

  p_wrap_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (active_w && !ext_w && !hold_w && !wr_cnt && (cnt_w + 1'b1 == lo_w)) |=> (cnt_w == '0));

  p_hold_zero_r8: assert property (@(posedge clk) disable iff (rst)
    hold_w |=> (cnt_w == '0));

  p_irq_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (irq_out && !bus_wr) |=> irq_out);

  p_unmapped_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_addr > 3) |=> (bus_rdata == '0));
endmodule

bind pwmtc_chan pwmtc_chk #(.DW(DW), .AW(AW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .pwm_out   (pwm_out),
  .irq_out   (irq_out),
  .cnt_w     (cnt_w),
  .hi_w      (hi_w),
  .lo_w      (lo_w),
  .active_w  (active_w),
  .ext_w     (ext_w),
  .hold_w    (hold_w)
);

// File: tb/pwmtc_chan_tb_top.sv
`timescale 1ns/1ps
module pwmtc_chan_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ext_tick_in = 1'b0;
  logic        cap_in = 1'b0;
  logic        pwm_out, irq_out;

  always #5 clk = ~clk;

  pwmtc_chan #(.DW(32), .AW(4)) dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_tick_in(ext_tick_in),
    .cap_in(cap_in), .pwm_out(pwm_out), .irq_out(irq_out)
  );

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;

  logic [31:0] m_cnt = '0, m_hi = '0, m_lo = '0;
  logic [8:0]  m_ctrl = '0;
  logic        m_pe = 1'b0, m_pc = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock with model prediction of pwm_out, irq_out and bus_rdata
  task automatic step(input logic wr, input logic [3:0] a, input logic [31:0] d, input string tag);
    logic [31:0] nc, nh, nl, nr;
    logic [8:0]  nct;
    logic ee, ce, act, tk, ld, stp, wrp, ep, cp, e_pwm;
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d;
    ep  = ext_tick_in; cp = cap_in;
    ee  = m_ctrl[2] ? (m_pe & ~ep) : (~m_pe & ep);
    ce  = m_ctrl[2] ? (m_pc & ~cp) : (~m_pc & cp);
    act = m_ctrl[0] & m_ctrl[3];
    tk  = m_ctrl[1] ? ee : 1'b1;
    ld  = wr && (a == 4'd0);
    stp = act && tk && !m_ctrl[7] && !ld;
    wrp = stp && (m_cnt + 32'd1 == m_lo);
    if (m_ctrl[7]) nc = '0;
    else if (ld)   nc = d;
    else if (stp)  nc = wrp ? 32'd0 : m_cnt + 32'd1;
    else           nc = m_cnt;
    if (wr && a == 4'd1)        nh = d;
    else if (m_ctrl[8] && ce)   nh = m_cnt;
    else                        nh = m_hi;
    nl = (wr && a == 4'd2) ? d : m_lo;
    nct = m_ctrl;
    if (wr && a == 4'd3) nct = d[8:0];
    else if (wrp && m_ctrl[4]) nct[0] = 1'b0;
    nct[6] = wrp | (m_ctrl[6] & !(wr && a == 4'd3 && d[6]));
    case (a)
      4'd0: nr = m_cnt;
      4'd1: nr = m_hi;
      4'd2: nr = m_lo;
      4'd3: nr = {23'd0, m_ctrl};
      default: nr = '0;
    endcase
    e_pwm = act && (nc >= m_hi) && (nc < m_lo);
    @(posedge clk);
    #1;
    m_cnt = nc; m_hi = nh; m_lo = nl; m_ctrl = nct; m_pe = ep; m_pc = cp;
    chk("R5 pwm_out", {31'd0, pwm_out}, {31'd0, e_pwm});
    chk("R7 irq_out", {31'd0, irq_out}, {31'd0, nct[6] & nct[5]});
    chk(tag, bus_rdata, nr);
    bus_wr = 1'b0;
  endtask

  task automatic wreg(input logic [3:0] a, input logic [31:0] d);
    step(1'b1, a, d, "R1 rdata");
  endtask

  task automatic rreg(input logic [3:0] a, input string tag, output logic [31:0] v);
    step(1'b0, a, 32'd0, tag);
    v = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 4'd0, 32'd0, "R1 rdata");
  endtask

  task automatic count_high(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      step(1'b0, 4'd0, 32'd0, "R1 rdata");
      h += int'(pwm_out);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int h;
    void'($urandom(32'd1357));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R11: reset state
    chk("R11 pwm_out after reset", {31'd0, pwm_out}, 32'd0);
    chk("R11 irq_out after reset", {31'd0, irq_out}, 32'd0);
    chk("R11 rdata after reset", bus_rdata, 32'd0);
    for (int a = 0; a < 4; a++) begin
      rreg(4'(a), "R11 register read", v);
      chk("R11 register zero", v, 32'd0);
    end

    // R5 / R4: period 10, normal polarity duty 3
    wreg(4'd2, 32'd10); wreg(4'd1, 32'd7); wreg(4'd0, 32'd0); wreg(4'd3, 32'h9);
    idle(20);
    count_high(10, h);
    chk("R5 duty 3 of period 10", h, 32'd3);
    // R5: equal references keep output low
    wreg(4'd1, 32'd10); idle(2);
    count_high(20, h);
    chk("R5 equal refs low", h, 32'd0);
    // R5: high ref 0 gives constant high
    wreg(4'd1, 32'd0); idle(2);
    count_high(10, h);
    chk("R5 full duty", h, 32'd10);

    // R7: pending, enable, write-1-to-clear
    wreg(4'd2, 32'd1000); wreg(4'd3, 32'h29); wreg(4'd0, 32'd995);
    idle(6);
    rreg(4'd3, "R7 ctrl read", v);
    chk("R7 pending set on wrap", v, 32'h69);
    chk("R7 irq high", {31'd0, irq_out}, 32'd1);
    wreg(4'd3, 32'h29);
    rreg(4'd3, "R7 ctrl read", v);
    chk("R7 write 0 keeps pending", v, 32'h69);
    wreg(4'd3, 32'h69);
    rreg(4'd3, "R7 ctrl read", v);
    chk("R7 write 1 clears pending", v, 32'h29);
    chk("R7 irq low after clear", {31'd0, irq_out}, 32'd0);

    // R6: single-shot
    wreg(4'd3, 32'h0); wreg(4'd2, 32'd5); wreg(4'd0, 32'd0); wreg(4'd3, 32'h19);
    idle(10);
    rreg(4'd3, "R6 ctrl read", v);
    chk("R6 run cleared after shot", v, 32'h58);
    rreg(4'd0, "R6 cnt read", v);
    chk("R6 counter stopped", v, 32'd0);
    idle(3);
    rreg(4'd0, "R6 cnt read", v);
    chk("R6 counter still stopped", v, 32'd0);

    // R8: hold overrides writes
    wreg(4'd3, 32'h89); wreg(4'd0, 32'd50);
    rreg(4'd0, "R8 cnt read", v);
    chk("R8 hold beats write", v, 32'd0);
    idle(3);
    rreg(4'd0, "R8 cnt read", v);
    chk("R8 hold keeps zero", v, 32'd0);

    // R9 / R3: load, and inactive channel does not count
    wreg(4'd3, 32'h0); wreg(4'd0, 32'd123);
    rreg(4'd0, "R9 cnt read", v);
    chk("R9 counter load", v, 32'd123);
    wreg(4'd3, 32'h1); idle(5);
    rreg(4'd0, "R3 cnt read", v);
    chk("R3 no count without output enable", v, 32'd123);
    chk("R3 output low when inactive", {31'd0, pwm_out}, 32'd0);

    // R10: capture, rising then falling (R2 bit 2)
    wreg(4'd3, 32'h100); wreg(4'd0, 32'd42);
    cap_in = 1'b1; idle(1);
    rreg(4'd1, "R10 hi read", v);
    chk("R10 rising capture", v, 32'd42);
    wreg(4'd3, 32'h104); wreg(4'd0, 32'd77);
    cap_in = 1'b0; idle(1);
    rreg(4'd1, "R10 hi read", v);
    chk("R10 falling capture R2", v, 32'd77);

    // R3: external ticks, rising then falling
    wreg(4'd3, 32'h0); wreg(4'd2, 32'd100); wreg(4'd1, 32'd100); wreg(4'd0, 32'd0);
    wreg(4'd3, 32'h0B);
    for (int i = 0; i < 6; i++) begin
      ext_tick_in = 1'b1; idle(1); ext_tick_in = 1'b0; idle(1);
    end
    rreg(4'd0, "R3 cnt read", v);
    chk("R3 six rising ticks", v, 32'd6);
    wreg(4'd3, 32'h0F);
    for (int i = 0; i < 4; i++) begin
      ext_tick_in = 1'b1; idle(1); ext_tick_in = 1'b0; idle(1);
    end
    rreg(4'd0, "R3 cnt read", v);
    chk("R3 four falling ticks", v, 32'd10);

    // R1: unmapped index
    wreg(4'd5, 32'hDEAD);
    rreg(4'd5, "R1 unmapped read", v);
    chk("R1 unmapped reads zero", v, 32'd0);
    rreg(4'd1, "R1 hi read", v);
    chk("R1 unmapped write ignored", v, 32'd100);

    // R2: control width
    wreg(4'd3, 32'hFFFF_FFFF);
    rreg(4'd3, "R2 ctrl read", v);
    chk("R2 control upper bits zero", v, 32'h1BF);
    wreg(4'd3, 32'h0);

    // random phase, checked every cycle against the model
    wreg(4'd2, 32'd12); wreg(4'd1, 32'd4); wreg(4'd0, 32'd0); wreg(4'd3, 32'h29);
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      logic [31:0] c;
      r = $urandom % 10;
      ext_tick_in = 1'($urandom);
      cap_in = ($urandom % 4 == 0) ? ~cap_in : cap_in;
      case (r)
        0: wreg(4'd2, 32'd2 + ($urandom % 23));
        1: wreg(4'd1, $urandom % 27);
        2: wreg(4'd0, $urandom % 25);
        3: begin
          c = $urandom & 32'h1FF;
          if ($urandom % 8 != 0) c[7] = 1'b0;
          if ($urandom % 2 == 0) c[3:0] = c[3:0] | 4'h9;
          wreg(4'd3, c);
        end
        default: step(1'b0, 4'($urandom % 8), 32'd0, "R1 random read");
      endcase
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule